// File: doc/BRIEF.md
# Delayed Push-Button Reset Controller

This block is a clocked reset supervisor. It turns a deliberate, long press of two push-buttons into a timed, active-low reset pulse. Short or one-handed presses never reach the reset output, so the same buttons can also drive an ordinary interrupt. A separate active-high instant input forces a reset at once, without any setup delay. A digital undervoltage flag from an external comparator holds the reset low for as long as it is set, and then for one more timeout.

Every timer advances on a single-cycle `tick` enable, nominally one per millisecond. All tick counts are parameters, so a simulation can shorten them. A two-bit static setting picks one of three button setup times. A build parameter picks one of two reset timeout lengths. All asynchronous inputs pass through two-flop synchronizers before they reach any timing logic.

Top module: `hold_reset_ctrl`

## Requirements
- R1: The reset output falls only after both button inputs have been low together for the selected number of setup ticks. Releasing either button earlier produces no reset, and the setup count starts again from zero on the next joint press.
- R2: `delaySel` picks the setup length: 2'b00 selects SETUP_SHORT_TICKS (2 s), 2'b01 selects SETUP_MID_TICKS (6 s), and 2'b10 or 2'b11 selects SETUP_LONG_TICKS (10 s).
- R3: Once a reset starts, `resetOutN` stays low for the timeout length and then returns high. The timeout is PULSE_SHORT_TICKS (210 ms) when LONG_TIMEOUT is 0, and PULSE_LONG_TICKS (360 ms) when it is 1.
- R4: A single button held low, however long, never asserts reset.
- R5: `resetOutN` is low out of reset (power-on pulse). It is held low while `lowSupply` is 1, and it rises one full timeout after `lowSupply` returns to 0.
- R6: A rising edge on `instantIn` drives `resetOutN` low within 4 clock cycles, with no setup delay and whatever the state of the buttons.
- R7: A rising edge on `instantIn` while the timeout is running restarts the timeout from zero.
- R8: For DEBOUNCE_TICKS (240 ms) after a reset pulse ends, rising edges on `instantIn` are ignored. After that window they are accepted again.
- R9: If both buttons are still held when a pulse ends, no new reset starts. Both buttons must first be released, and then held again for the full setup time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| tick | input | 1 | One-cycle timer enable, nominally 1 ms apart |
| btnAN | input | 1 | First push-button, active-low, asynchronous |
| btnBN | input | 1 | Second push-button, active-low, asynchronous |
| instantIn | input | 1 | Instant reset request, active-high, edge-triggered |
| lowSupply | input | 1 | Undervoltage flag from an external comparator |
| delaySel | input | 2 | Setup-time select (00 short, 01 mid, 1x long) |
| resetOutN | output | 1 | Reset output, active-low |

## Verification
The button path is driven with one button held alone, with a joint press released just before the setup ends followed by a full press, and with full presses under each `delaySel` code. Together these separate the both-low condition, the restart of the setup count, and the decoding of the three lengths; measuring the cycles from press to reset bounds each length. The instant input is raised from idle, again in mid-pulse, inside the debounce window and after it. This shows immediate assertion, timeout restart and edge rejection as distinct behaviours. Holding the buttons past the end of a pulse and holding `lowSupply` for longer than a pulse cover the re-arm rule and the post-flag timeout.

// File: rtl/hold_reset_pkg.sv
package hold_reset_pkg;

  // Strobes from control to the counter datapath
  typedef struct packed {
    logic setupInc;
    logic setupClr;
    logic pulseInc;
    logic pulseClr;
    logic dbInc;
    logic dbClr;
  } strobe_t;

  // Terminal-count flags from the datapath back to control
  typedef struct packed {
    logic setupHit;
    logic pulseHit;
    logic dbHit;
  } status_t;

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/hold_reset_sync.sv
module hold_reset_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage <= {STAGES{RESET_VAL}};
    else       stage <= {stage[STAGES-2:0], din};
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/hold_reset_datapath.sv
module hold_reset_datapath
  import hold_reset_pkg::*;
#(
  parameter int SETUP_SHORT_TICKS = 2000,
  parameter int SETUP_MID_TICKS   = 6000,
  parameter int SETUP_LONG_TICKS  = 10000,
  parameter int PULSE_TICKS       = 210,
  parameter int DEBOUNCE_TICKS    = 240,
  parameter int CNT_W             = 14
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    cmd,
  input  logic [1:0] sel,
  output status_t    stat
);

  logic [CNT_W-1:0] setupCnt;
  logic [CNT_W-1:0] pulseCnt;
  logic [CNT_W-1:0] dbCnt;
  logic [CNT_W-1:0] setupLast;

  always_comb begin
    case (sel)
      2'b00:   setupLast = CNT_W'(SETUP_SHORT_TICKS - 1);
      2'b01:   setupLast = CNT_W'(SETUP_MID_TICKS - 1);
      default: setupLast = CNT_W'(SETUP_LONG_TICKS - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      setupCnt <= '0;
      pulseCnt <= '0;
      dbCnt    <= '0;
    end else begin
      if (cmd.setupClr)      setupCnt <= '0;
      else if (cmd.setupInc) setupCnt <= setupCnt + 1'b1;
      if (cmd.pulseClr)      pulseCnt <= '0;
      else if (cmd.pulseInc) pulseCnt <= pulseCnt + 1'b1;
      if (cmd.dbClr)         dbCnt <= '0;
      else if (cmd.dbInc)    dbCnt <= dbCnt + 1'b1;
    end
  end

  assign stat.setupHit = (setupCnt == setupLast);
  assign stat.pulseHit = (pulseCnt == CNT_W'(PULSE_TICKS - 1));
  assign stat.dbHit    = (dbCnt == CNT_W'(DEBOUNCE_TICKS - 1));

endmodule

// File: rtl/hold_reset_control.sv
module hold_reset_control
  import hold_reset_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    tick,
  input  logic    btnA,
  input  logic    btnB,
  input  logic    inst,
  input  logic    low,
  input  status_t stat,
  output strobe_t cmd,
  output logic    pulseActive
);

  logic armed;
  logic dbActive;
  logic instPrev;
  logic bothLow, bothHigh, instRise;
  logic setupFire, instFire, start, pulseEnd, dbEnd;

  always_comb begin
    bothLow   = !btnA && !btnB;
    bothHigh  = btnA && btnB;
    instRise  = inst && !instPrev;
    setupFire = armed && bothLow && tick && stat.setupHit;
    instFire  = instRise && !dbActive;
    start     = setupFire || instFire || low;
    pulseEnd  = pulseActive && tick && stat.pulseHit && !start;
    dbEnd     = dbActive && tick && stat.dbHit;

    cmd.setupInc = armed && bothLow && tick && !stat.setupHit;
    cmd.setupClr = !(armed && bothLow) || setupFire;
    cmd.pulseInc = pulseActive && tick && !stat.pulseHit && !start;
    cmd.pulseClr = start || pulseEnd;
    cmd.dbInc    = dbActive && tick && !stat.dbHit && !start;
    cmd.dbClr    = pulseEnd || dbEnd || start;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed       <= 1'b0;
      pulseActive <= 1'b1;
      dbActive    <= 1'b0;
      instPrev    <= 1'b0;
    end else begin
      instPrev <= inst;
      if (setupFire)     armed <= 1'b0;
      else if (bothHigh) armed <= 1'b1;
      if (start)         pulseActive <= 1'b1;
      else if (pulseEnd) pulseActive <= 1'b0;
      if (pulseEnd)             dbActive <= 1'b1;
      else if (start || dbEnd)  dbActive <= 1'b0;
    end
  end

endmodule

// File: rtl/hold_reset_ctrl.sv
module hold_reset_ctrl
  import hold_reset_pkg::*;
#(
  parameter int SETUP_SHORT_TICKS = 2000,
  parameter int SETUP_MID_TICKS   = 6000,
  parameter int SETUP_LONG_TICKS  = 10000,
  parameter bit LONG_TIMEOUT      = 1'b0,
  parameter int PULSE_SHORT_TICKS = 210,
  parameter int PULSE_LONG_TICKS  = 360,
  parameter int DEBOUNCE_TICKS    = 240
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       btnAN,
  input  logic       btnBN,
  input  logic       instantIn,
  input  logic       lowSupply,
  input  logic [1:0] delaySel,
  output logic       resetOutN
);

  localparam int PULSE_TICKS = LONG_TIMEOUT ? PULSE_LONG_TICKS : PULSE_SHORT_TICKS;
  localparam int MAX_SETUP   = maxInt(maxInt(SETUP_SHORT_TICKS, SETUP_MID_TICKS), SETUP_LONG_TICKS);
  localparam int MAX_ALL     = maxInt(maxInt(MAX_SETUP, PULSE_TICKS), DEBOUNCE_TICKS);
  localparam int CNT_W       = $clog2(MAX_ALL + 1);
  localparam int SYNC_W      = 6;

  logic [SYNC_W-1:0] rawIn, syncOut;
  logic [1:0] syncSel;
  logic syncA, syncB, syncInst, syncLow;
  logic pulseActive;
  strobe_t cmd;
  status_t stat;

  assign rawIn = {lowSupply, instantIn, btnBN, btnAN, delaySel};

  hold_reset_sync #(
    .WIDTH(SYNC_W), .STAGES(2), .RESET_VAL(6'b0_0_1_1_00)
  ) sync_i (
    .clk(clk), .rstN(rstN), .din(rawIn), .dout(syncOut)
  );

  assign {syncLow, syncInst, syncB, syncA, syncSel} = syncOut;

  hold_reset_control ctl_i (
    .clk(clk), .rstN(rstN), .tick(tick), .btnA(syncA), .btnB(syncB),
    .inst(syncInst), .low(syncLow), .stat(stat), .cmd(cmd),
    .pulseActive(pulseActive)
  );

  hold_reset_datapath #(
    .SETUP_SHORT_TICKS(SETUP_SHORT_TICKS), .SETUP_MID_TICKS(SETUP_MID_TICKS),
    .SETUP_LONG_TICKS(SETUP_LONG_TICKS), .PULSE_TICKS(PULSE_TICKS),
    .DEBOUNCE_TICKS(DEBOUNCE_TICKS), .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .sel(syncSel), .stat(stat)
  );

  assign resetOutN = !pulseActive;

endmodule

// File: rtl/hold_reset_checker.sv
module hold_reset_checker (
  input logic clk,
  input logic rstN,
  input logic tick,
  input logic resetOutN,
  input logic syncA,
  input logic syncB,
  input logic syncInst,
  input logic syncLow
);

  // R5: undervoltage forces the output low on the next cycle
  assert_hold_on_low_supply_R5: assert property (@(posedge clk) disable iff (!rstN)
    syncLow |=> !resetOutN);

  // R4 / R1: with no joint press, no supply flag and no instant edge, the output stays high
  assert_no_fire_without_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    (resetOutN && !(!syncA && !syncB) && !syncLow && !(syncInst && !$past(syncInst)))
    |=> resetOutN);

  // R6 / R1: every falling edge of the output has one of its three causes a cycle earlier
  assert_fall_has_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resetOutN) |-> $past(syncLow || (!syncA && !syncB) || syncInst));

  // R3 / R5: the output rises only on a tick, with the supply flag clear
  assert_release_on_tick_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetOutN) |-> ($past(tick) && !$past(syncLow)));

endmodule

bind hold_reset_ctrl hold_reset_checker chk_i (
  .clk(clk), .rstN(rstN), .tick(tick), .resetOutN(resetOutN),
  .syncA(syncA), .syncB(syncB), .syncInst(syncInst), .syncLow(syncLow)
);

// File: tb/hold_reset_ctrl_tb.sv
module hold_reset_ctrl_tb_top;

  localparam int S_SHORT = 20;
  localparam int S_MID   = 30;
  localparam int S_LONG  = 40;
  localparam int PT      = 30;
  localparam int DB      = 25;
  localparam int TP      = 4;     // clock cycles per tick
  localparam int LIMIT   = 3000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic btnAN = 1'b1, btnBN = 1'b1, instantIn = 1'b0, lowSupply = 1'b0;
  logic [1:0] delaySel = 2'b00;
  logic resetOutN;
  int tickCnt = 0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  always @(posedge clk) begin
    tickCnt <= (tickCnt == TP - 1) ? 0 : tickCnt + 1;
    tick    <= (tickCnt == TP - 1);
  end

  hold_reset_ctrl #(
    .SETUP_SHORT_TICKS(S_SHORT), .SETUP_MID_TICKS(S_MID), .SETUP_LONG_TICKS(S_LONG),
    .LONG_TIMEOUT(1'b0), .PULSE_SHORT_TICKS(PT), .PULSE_LONG_TICKS(2 * PT),
    .DEBOUNCE_TICKS(DB)
  ) dut_i (
    .clk(clk), .rstN(rstN), .tick(tick), .btnAN(btnAN), .btnBN(btnBN),
    .instantIn(instantIn), .lowSupply(lowSupply), .delaySel(delaySel),
    .resetOutN(resetOutN)
  );

  typedef struct {
    string req;
    bit    isSpan;
    int    val;
    int    lo;
    int    hi;
  } item_t;

  item_t expQ[$];

  // Monitor: pops expected items and compares them away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        checks++;
        if (it.isSpan) begin
          if (it.val < it.lo || it.val > it.hi) begin
            errors++;
            $display("FAIL %s: span %0d cycles, expected %0d..%0d", it.req, it.val, it.lo, it.hi);
          end
        end else if (resetOutN !== it.val[0]) begin
          errors++;
          $display("FAIL %s: resetOutN=%0b expected %0b", it.req, resetOutN, it.val[0]);
        end
      end
    end
  end

  task automatic expectLevel(input string req, input bit lvl);
    item_t it;
    it.req = req; it.isSpan = 1'b0; it.val = int'(lvl); it.lo = 0; it.hi = 0;
    expQ.push_back(it);
  endtask

  task automatic expectTicks(input string req, input int n, input int k);
    item_t it;
    it.req = req; it.isSpan = 1'b1; it.val = n;
    it.lo = (k - 1) * TP - 2; it.hi = k * TP + 6;
    expQ.push_back(it);
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic waitLevel(input bit lvl, output int n);
    n = 0;
    while (resetOutN !== lvl && n < LIMIT) begin
      @(posedge clk);
      #1;
      n++;
    end
  endtask

  task automatic setBoth(input bit v);
    btnAN = v;
    btnBN = v;
  endtask

  task automatic quiet();
    waitCycles((DB + 3) * TP);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run still busy, expected completion");
    finishRun();
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R5: power-on pulse
    expectLevel("R5 power-on low", 1'b0);
    waitLevel(1'b1, n);
    expectTicks("R5 power-on length", n, PT);
    quiet();

    // R4: one button alone never resets
    btnAN = 1'b0;
    waitCycles((S_LONG + 5) * TP);
    expectLevel("R4 only A low", 1'b1);
    btnAN = 1'b1;
    btnBN = 1'b0;
    waitCycles((S_LONG + 5) * TP);
    expectLevel("R4 only B low", 1'b1);
    btnBN = 1'b1;
    waitCycles(8);

    // R1: short joint press, then full press measured from its own start
    delaySel = 2'b00;
    setBoth(1'b0);
    waitCycles((S_SHORT - 4) * TP);
    setBoth(1'b1);
    waitCycles(4 * TP);
    expectLevel("R1 early release", 1'b1);
    waitCycles(S_SHORT * TP);
    expectLevel("R1 no late response", 1'b1);
    setBoth(1'b0);
    waitLevel(1'b0, n);
    expectTicks("R1 setup restarted", n, S_SHORT);
    waitLevel(1'b1, n);
    expectTicks("R3 pulse length", n, PT);

    // R9: still held after pulse, then release and press again
    waitCycles((S_SHORT + 5) * TP);
    expectLevel("R9 held no retrigger", 1'b1);
    setBoth(1'b1);
    quiet();
    setBoth(1'b0);
    waitLevel(1'b0, n);
    expectTicks("R9 rearmed press", n, S_SHORT);
    setBoth(1'b1);
    waitLevel(1'b1, n);
    quiet();

    // R2: the other setup codes
    delaySel = 2'b01;
    waitCycles(4);
    setBoth(1'b0);
    waitLevel(1'b0, n);
    expectTicks("R2 sel=01 mid", n, S_MID);
    setBoth(1'b1);
    waitLevel(1'b1, n);
    quiet();
    delaySel = 2'b10;
    waitCycles(4);
    setBoth(1'b0);
    waitLevel(1'b0, n);
    expectTicks("R2 sel=10 long", n, S_LONG);
    setBoth(1'b1);
    waitLevel(1'b1, n);
    quiet();
    delaySel = 2'b11;
    waitCycles(4);
    setBoth(1'b0);
    waitLevel(1'b0, n);
    expectTicks("R2 sel=11 long", n, S_LONG);
    setBoth(1'b1);
    waitLevel(1'b1, n);
    quiet();

    // R6: instant edge asserts at once
    instantIn = 1'b1;
    waitCycles(4);
    expectLevel("R6 instant low", 1'b0);
    instantIn = 1'b0;
    // R7: second edge mid-pulse restarts the timeout
    waitCycles((PT / 2) * TP);
    instantIn = 1'b1;
    waitLevel(1'b1, n);
    expectTicks("R7 timeout restarted", n, PT);
    // R8: edge inside the debounce window is ignored
    instantIn = 1'b0;
    waitCycles(4);
    instantIn = 1'b1;
    waitCycles(8);
    expectLevel("R8 edge in window ignored", 1'b1);
    instantIn = 1'b0;
    quiet();
    instantIn = 1'b1;
    waitCycles(4);
    expectLevel("R8 edge after window accepted", 1'b0);
    instantIn = 1'b0;
    waitLevel(1'b1, n);
    quiet();

    // R5: undervoltage hold and trailing timeout
    lowSupply = 1'b1;
    waitCycles(4);
    expectLevel("R5 low supply asserts", 1'b0);
    waitCycles(2 * PT * TP);
    expectLevel("R5 held while flag set", 1'b0);
    lowSupply = 1'b0;
    waitLevel(1'b1, n);
    expectTicks("R5 timeout after flag clears", n, PT);

    waitCycles(4);
    @(negedge clk);
    @(negedge clk);
    finishRun();
  end

endmodule